// File: doc/BRIEF.md
# Multicontext Configuration Store with Sequencing Pointer

This block keeps a bank of configuration words, or contexts, for a single element of a reconfigurable array. A pointer picks which stored word drives the element. The pointer only reselects among words already in the bank, so the element's function changes in one clock and nothing has to be fetched. The word that drives the element, `activeCfg`, comes from a register. It therefore shows the slot that the pointer held in the previous cycle.

A small sequencer runs a task, which is a run of consecutive slots. The task is given by a first slot, a last slot and a dwell count, which sets how many cycles each context stays active. The pointer starts at the first slot and steps one slot at a time. After the last slot of the bank it wraps to slot 0. Once the last context has used its dwell time, the sequencer reports completion and leaves the pointer where it is.

A central configuration memory fills the bank through a write port. A write is refused if its target is the slot the pointer selects at that moment, and a refused write raises an error flag. Because of this rule, a task can be reloaded while another task is running, and the running task is never disturbed.

Top module: `ctx_switch_store`

## Requirements
- R1: While reset is low and in the first cycle after it, `ctxPtr`, `activeCfg`, `busy`, `done` and `loadErr` are all zero, and every slot holds zero.
- R2: A write with `loadEn` high to any slot other than the one `ctxPtr` selects stores `loadData` in slot `loadAddr` at that clock edge. `loadErr` stays low in the next cycle.
- R3: A write whose `loadAddr` equals `ctxPtr` leaves the slot unchanged. `loadErr` is high for exactly the next cycle.
- R4: When `taskStart` is high while the sequencer is idle or done, `ctxPtr` equals `taskFirst` after the next edge, `busy` is 1 and `done` is 0.
- R5: While running, each context stays on `ctxPtr` for `taskDwell`+1 cycles. The pointer then moves up by one, and from `NUM_CTX`-1 it moves to 0.
- R6: When the context at `taskLast` has used its dwell, `busy` falls and `done` rises at the same edge. `ctxPtr` then holds its value until the next accepted start.
- R7: `activeCfg` equals the contents of the slot that `ctxPtr` selected one cycle earlier. A new context therefore takes effect one clock after the pointer moves.
- R8: `taskStart` has no effect while `busy` is high. The pointer, the dwell timing and the end slot of the running task are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write strobe from the configuration memory |
| loadAddr | input | PTR_W | Slot to write |
| loadData | input | CFG_W | Configuration word to store |
| loadErr | output | 1 | Pulses one cycle after a refused write to the active slot |
| taskStart | input | 1 | Starts a task (accepted when idle or done) |
| taskFirst | input | PTR_W | First slot of the task |
| taskLast | input | PTR_W | Last slot of the task |
| taskDwell | input | DWELL_W | Extra cycles each context stays active |
| busy | output | 1 | Task running |
| done | output | 1 | Task finished; pointer held |
| ctxPtr | output | PTR_W | Context pointer |
| activeCfg | output | CFG_W | Registered active configuration word |

## Verification
The bench runs every pair of first and last slot in an 8-slot bank with dwell values 0, 1 and 3. This sweep covers single-slot tasks, tasks that fill the whole bank and tasks that wrap past the top slot, and it separates the cases where the dwell timing, the increment or the wrap is wrong. Each slot holds a distinct word, so an error in the pointer or a missing cycle of output delay shows up as a wrong word on `activeCfg`. Separate patterns cover a write to the active slot against a write to another slot, both at idle and after completion, and a restart request sent mid-task, which tests whether requests are ignored while busy.

// File: rtl/ctx_store_pkg.sv
package ctx_store_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;

  // strobes from the sequencer to the slot bank
  typedef struct packed {
    logic ptrSet;   // load pointer with the task's first slot
    logic ptrStep;  // advance pointer by one slot, wrapping
  } ptrCmd_t;

endpackage

// File: rtl/ctx_slot_bank.sv
module ctx_slot_bank
  import ctx_store_pkg::*;
#(
  parameter int CFG_W   = 16,
  parameter int NUM_CTX = 64,
  parameter int PTR_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptrCmd_t          cmd,
  input  logic [PTR_W-1:0] setPtr,
  input  logic             loadEn,
  input  logic [PTR_W-1:0] loadAddr,
  input  logic [CFG_W-1:0] loadData,
  output logic [PTR_W-1:0] ctxPtr,
  output logic [CFG_W-1:0] activeCfg,
  output logic             loadErr
);

  localparam logic [PTR_W-1:0] TOP_SLOT = PTR_W'(NUM_CTX - 1);

  logic [CFG_W-1:0] slotQ [NUM_CTX];
  logic             hitActive;
  logic             wrOk;
  logic [PTR_W-1:0] ptrNext;

  assign hitActive = loadEn && (loadAddr == ctxPtr);
  assign wrOk      = loadEn && !hitActive;

  // one storage row per context, each with its own write decode
  for (genvar g = 0; g < NUM_CTX; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[g] <= '0;
      end else if (wrOk && (loadAddr == PTR_W'(g))) begin
        slotQ[g] <= loadData;
      end
    end
  end

  always_comb begin
    ptrNext = ctxPtr;
    if (cmd.ptrSet) begin
      ptrNext = setPtr;
    end else if (cmd.ptrStep) begin
      ptrNext = (ctxPtr == TOP_SLOT) ? '0 : ctxPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxPtr    <= '0;
      activeCfg <= '0;
      loadErr   <= 1'b0;
    end else begin
      ctxPtr    <= ptrNext;
      activeCfg <= slotQ[ctxPtr];
      loadErr   <= hitActive;
    end
  end

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && loadAddr == ctxPtr) |=> loadErr); // R3

  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    $stable(ctxPtr) |=> $stable(activeCfg)); // R7

endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
  import ctx_store_pkg::*;
#(
  parameter int NUM_CTX = 64,
  parameter int PTR_W   = 6,
  parameter int DWELL_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               taskStart,
  input  logic [PTR_W-1:0]   taskFirst,
  input  logic [PTR_W-1:0]   taskLast,
  input  logic [DWELL_W-1:0] taskDwell,
  input  logic [PTR_W-1:0]   ctxPtr,
  output ptrCmd_t            cmd,
  output logic               busy,
  output logic               done
);

  seqState_t          state;
  seqState_t          stateNext;
  logic [PTR_W-1:0]   lastQ;
  logic [DWELL_W-1:0] dwellQ;
  logic [DWELL_W-1:0] dwellCnt;
  logic               dwellEnd;
  logic               accept;

  assign dwellEnd = (dwellCnt == dwellQ);
  assign accept   = taskStart && (state != SEQ_RUN);

  always_comb begin
    cmd       = '0;
    stateNext = state;
    unique case (state)
      SEQ_IDLE, SEQ_DONE: begin
        if (taskStart) begin
          cmd.ptrSet = 1'b1;
          stateNext  = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (dwellEnd) begin
          if (ctxPtr == lastQ) begin
            stateNext = SEQ_DONE;
          end else begin
            cmd.ptrStep = 1'b1;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      lastQ    <= '0;
      dwellQ   <= '0;
      dwellCnt <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        lastQ    <= taskLast;
        dwellQ   <= taskDwell;
        dwellCnt <= '0;
      end else if (state == SEQ_RUN) begin
        dwellCnt <= dwellEnd ? '0 : dwellCnt + 1'b1;
      end
    end
  end

  assign busy = (state == SEQ_RUN);
  assign done = (state == SEQ_DONE);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && taskStart) |=> (busy && ctxPtr == $past(taskFirst))); // R4

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dwellEnd) |=> $stable(ctxPtr)); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dwellEnd && ctxPtr != lastQ) |=>
      (ctxPtr == (($past(ctxPtr) == PTR_W'(NUM_CTX - 1)) ? '0 : $past(ctxPtr) + 1'b1))); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !taskStart) |=> (done && $stable(ctxPtr))); // R6

endmodule

// File: rtl/ctx_switch_store.sv
module ctx_switch_store
  import ctx_store_pkg::*;
#(
  parameter int CFG_W   = 16,
  parameter int NUM_CTX = 64,
  parameter int DWELL_W = 4,
  localparam int PTR_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [PTR_W-1:0]   loadAddr,
  input  logic [CFG_W-1:0]   loadData,
  output logic               loadErr,
  input  logic               taskStart,
  input  logic [PTR_W-1:0]   taskFirst,
  input  logic [PTR_W-1:0]   taskLast,
  input  logic [DWELL_W-1:0] taskDwell,
  output logic               busy,
  output logic               done,
  output logic [PTR_W-1:0]   ctxPtr,
  output logic [CFG_W-1:0]   activeCfg
);

  ptrCmd_t ptrCmd;

  ctx_seq_fsm #(
    .NUM_CTX (NUM_CTX),
    .PTR_W   (PTR_W),
    .DWELL_W (DWELL_W)
  ) i_seq (
    .clk       (clk),
    .rstN      (rstN),
    .taskStart (taskStart),
    .taskFirst (taskFirst),
    .taskLast  (taskLast),
    .taskDwell (taskDwell),
    .ctxPtr    (ctxPtr),
    .cmd       (ptrCmd),
    .busy      (busy),
    .done      (done)
  );

  ctx_slot_bank #(
    .CFG_W   (CFG_W),
    .NUM_CTX (NUM_CTX),
    .PTR_W   (PTR_W)
  ) i_bank (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (ptrCmd),
    .setPtr    (taskFirst),
    .loadEn    (loadEn),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .ctxPtr    (ctxPtr),
    .activeCfg (activeCfg),
    .loadErr   (loadErr)
  );

endmodule

// File: tb/test_ctx_switch_store.sv
module test_ctx_switch_store;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W   = 16;
  localparam int NUM_CTX = 8;
  localparam int DWELL_W = 3;
  localparam int PTR_W   = 3;

  logic               clk = 1'b0;
  logic               rstN;
  logic               loadEn;
  logic [PTR_W-1:0]   loadAddr;
  logic [CFG_W-1:0]   loadData;
  logic               loadErr;
  logic               taskStart;
  logic [PTR_W-1:0]   taskFirst;
  logic [PTR_W-1:0]   taskLast;
  logic [DWELL_W-1:0] taskDwell;
  logic               busy;
  logic               done;
  logic [PTR_W-1:0]   ctxPtr;
  logic [CFG_W-1:0]   activeCfg;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [CFG_W-1:0] slotModel [NUM_CTX];
  int expPtr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctx_switch_store #(
    .CFG_W   (CFG_W),
    .NUM_CTX (NUM_CTX),
    .DWELL_W (DWELL_W)
  ) i_ctx_switch_store (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .loadErr   (loadErr),
    .taskStart (taskStart),
    .taskFirst (taskFirst),
    .taskLast  (taskLast),
    .taskDwell (taskDwell),
    .busy      (busy),
    .done      (done),
    .ctxPtr    (ctxPtr),
    .activeCfg (activeCfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CFG_W-1:0] pattern(input int i, input int salt);
    return CFG_W'(16'hA000 + salt * 16'h0100 + i * 16'h0011);
  endfunction

  task automatic doLoad(input int addr, input logic [CFG_W-1:0] data);
    bit reject;
    reject   = (addr == expPtr);
    loadEn   = 1'b1;
    loadAddr = PTR_W'(addr);
    loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
    if (reject) begin
      chk(loadErr == 1'b1, "R3 loadErr after write to active slot", 32'(loadErr), 32'd1);
    end else begin
      chk(loadErr == 1'b0, "R2 loadErr after accepted write", 32'(loadErr), 32'd0);
      slotModel[addr] = data;
    end
    @(negedge clk);
    chk(loadErr == 1'b0, "R3 loadErr is a single-cycle pulse", 32'(loadErr), 32'd0);
  endtask

  task automatic runTask(input int first, input int last, input int dwell, input bit midStart);
    int n;
    int total;
    int prevPtr;
    int idx;
    int ePtr;
    n     = ((last - first + NUM_CTX) % NUM_CTX) + 1;
    total = n * (dwell + 1);
    prevPtr = expPtr;
    taskStart = 1'b1;
    taskFirst = PTR_W'(first);
    taskLast  = PTR_W'(last);
    taskDwell = DWELL_W'(dwell);
    @(negedge clk);
    taskStart = 1'b0;
    for (int j = 0; j <= total + 1; j++) begin
      idx  = j / (dwell + 1);
      if (idx > n - 1) idx = n - 1;
      ePtr = (first + idx) % NUM_CTX;
      if (j == 0)
        chk(int'(ctxPtr) == ePtr, "R4 pointer loaded from first slot", 32'(ctxPtr), 32'(ePtr));
      else
        chk(int'(ctxPtr) == ePtr, "R5 pointer stepping and dwell", 32'(ctxPtr), 32'(ePtr));
      chk({busy, done} == {(j < total), (j >= total)}, "R6 busy/done status",
          32'({busy, done}), 32'({(j < total), (j >= total)}));
      chk(activeCfg == slotModel[prevPtr], "R7 registered active word",
          32'(activeCfg), 32'(slotModel[prevPtr]));
      prevPtr = ePtr;
      if (midStart && j == 0) begin
        // R8: restart request while busy must not disturb the run
        taskStart = 1'b1;
        taskFirst = PTR_W'((first + 3) % NUM_CTX);
        taskLast  = PTR_W'(first);
        taskDwell = '0;
      end else begin
        taskStart = 1'b0;
      end
      @(negedge clk);
    end
    expPtr = last;
    chk(int'(ctxPtr) == last, "R6 pointer held after done", 32'(ctxPtr), 32'(last));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; loadEn = 1'b0; loadAddr = '0; loadData = '0;
    taskStart = 1'b0; taskFirst = '0; taskLast = '0; taskDwell = '0;
    for (int i = 0; i < NUM_CTX; i++) slotModel[i] = '0;
    repeat (3) @(negedge clk);
    chk({ctxPtr, busy, done, loadErr} == '0, "R1 status in reset", 32'({ctxPtr, busy, done, loadErr}), 32'd0);
    chk(activeCfg == '0, "R1 active word in reset", 32'(activeCfg), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk({ctxPtr, busy, done, loadErr} == '0, "R1 status after reset", 32'({ctxPtr, busy, done, loadErr}), 32'd0);
    chk(activeCfg == '0, "R1 active word after reset", 32'(activeCfg), 32'd0);

    // R2: fill every slot except the active one; R3: try the active one
    for (int i = 1; i < NUM_CTX; i++) doLoad(i, pattern(i, 0));
    doLoad(0, pattern(0, 0));
    runTask(0, 0, 0, 1'b0);           // R3 slot 0 still reads zero
    runTask(1, 1, 0, 1'b0);
    doLoad(0, pattern(0, 0));         // now accepted

    // sweep of all first/last pairs and several dwell values (R4-R7)
    for (int d = 0; d < 3; d++) begin
      for (int f = 0; f < NUM_CTX; f++) begin
        for (int l = 0; l < NUM_CTX; l++) begin
          runTask(f, l, (d == 2) ? 3 : d, 1'b0);
        end
      end
    end

    // R8: start request during a run is ignored
    runTask(2, 6, 1, 1'b1);
    runTask(6, 1, 0, 1'b1);

    // R3 after done: active slot 1 cannot be rewritten, active word steady
    doLoad(1, 16'h5A5A);
    repeat (2) @(negedge clk);
    chk(activeCfg == slotModel[1], "R3 active word unchanged by refused write",
        32'(activeCfg), 32'(slotModel[1]));
    // R2: another slot takes new data and shows it when selected
    doLoad(5, 16'h3C3C);
    runTask(5, 5, 0, 1'b0);
    chk(activeCfg == 16'h3C3C, "R2 new word visible once selected", 32'(activeCfg), 32'h3C3C);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule